// File: doc/BRIEF.md
# Banked Interrupt Status Controller

This block gathers interrupt sources in several identical banks of 32 lines each. Every raw source line is level-sensitive. On every clock cycle in which a source line is high, the block sets the matching pending bit in that bank's status register. The pending bit stays set until software clears it by writing a one to it. A per-bank enable register decides which pending bits may reach the processor. The AND of status and enable forms the masked view. When any bit of the masked view is set, that bank's request line is high.

Each bank also provides the index of the highest-numbered bit in its masked view. An interrupt handler can use this index to dispatch directly, without scanning the register.

Software reaches all registers over a simple synchronous bus with an address, write data, a write strobe, a read strobe and registered read data. Each bank's register group sits at a fixed stride of 0x28 bytes. Inside a group, status is at 0x00, enable at 0x08 and masked view at 0x10. Two reserved words at 0x18 and 0x20 read as zero.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, all status and enable bits are 0, every request output is low, and read data is 0.
- R2: A raw source that is high at a clock edge sets its status bit, and the bit stays set after the source goes low.
- R3: Writing to status offset 0x00 of bank n (address n*0x28) clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears the whole bank.
- R4: If a source is high in the same cycle as a clear write to its bit, the status bit stays set.
- R5: The enable register at offset 0x08 is read/write. Clearing an enable bit blocks that source from the request but keeps its status bit.
- R6: Offset 0x10 reads as status AND enable, and writes to it have no effect.
- R7: The request output of bank n is high exactly when bank n's masked view is non-zero, one cycle after the status or enable register changes.
- R8: The vector output of bank n is the index of the most-significant set bit of the masked view. It is 0 when the masked view is empty.
- R9: Offsets 0x18 and 0x20, and addresses beyond the last bank, read as zero and ignore writes.
- R10: Read data appears on the clock edge after a read strobe, and is 0 in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_raw | input | 160 | Raw source lines; bank n uses bits [32n+31:32n] |
| irq_req | output | 5 | Per-bank request to the processor |
| irq_vec | output | 25 | Per-bank top pending index, 5 bits per bank |

## Verification
The per-cycle assertions check three properties. A request always matches a non-zero masked view. A status bit whose source was high never drops on the next cycle. Vector and request always agree: an empty masked view gives a vector of zero.

Only the bench scenarios can show the following behaviours:
- the exact bit positions and addresses used for clears and enables;
- the priority ordering of the vector under varied patterns;
- the collision between a source event and a clear write;
- the read-as-zero behaviour of reserved and masked offsets.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned BANK_STRIDE = 'h28;
   localparam logic [5:0] OFS_STATUS = 6'h00;
   localparam logic [5:0] OFS_ENABLE = 6'h08;
   localparam logic [5:0] OFS_MASKED = 6'h10;

   typedef enum logic [1:0] {
      SEL_STATUS,
      SEL_ENABLE,
      SEL_MASKED,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_bank_pkg::*;
#(
   parameter int unsigned NBANK  = 5,
   parameter int unsigned ADDR_W = 12,
   localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BIDX_W-1:0] bank_idx,
   output logic              bank_hit,
   output reg_sel_e          sel
);
   logic [ADDR_W-1:0] offs;

   initial begin
      if (NBANK * BANK_STRIDE > (1 << ADDR_W))
         $error("irq_addr_dec: address width too small for bank count");
   end

   always_comb begin
      bank_idx = '0;
      bank_hit = 1'b0;
      offs     = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (addr >= ADDR_W'(b * BANK_STRIDE) && addr < ADDR_W'((b + 1) * BANK_STRIDE)) begin
            bank_idx = BIDX_W'(b);
            bank_hit = 1'b1;
            offs     = addr - ADDR_W'(b * BANK_STRIDE);
         end
      end
      sel = SEL_NONE;
      if (bank_hit) begin
         case (offs[5:0])
            OFS_STATUS: sel = SEL_STATUS;
            OFS_ENABLE: sel = SEL_ENABLE;
            OFS_MASKED: sel = SEL_MASKED;
            default:    sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
   parameter int unsigned W = 32,
   localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = 0; i < W; i++)
         if (vec[i]) idx = IDX_W'(i);
   end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
   import irq_bank_pkg::*;
#(
   parameter int unsigned W = 32,
   localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     src,
   input  logic             wr_stat,
   input  logic             wr_en,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     status,
   output logic [W-1:0]     enable,
   output logic [W-1:0]     masked,
   output logic             req,
   output logic [IDX_W-1:0] vec
);
   logic [W-1:0] clr;
   logic         any;

   assign clr    = wr_stat ? wdata : '0;
   assign masked = status & enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~clr) | src;
         if (wr_en) enable <= wdata;
      end
   end

   irq_msb_find #(.W(W)) u_find (.vec(masked), .idx(vec), .any(any));
   assign req = any;

   // R7
   req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req == (|(status & enable)));
   // R4
   src_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src != '0) |=> ((status & $past(src)) == $past(src)));
   // R8
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (vec == '0));
   // R8
   vec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> masked[vec]);
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
   import irq_bank_pkg::*;
#(
   parameter int unsigned NBANK  = 5,
   parameter int unsigned ADDR_W = 12,
   localparam int unsigned W     = REG_W,
   localparam int unsigned IDX_W = $clog2(W),
   localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [W-1:0]          bus_wdata,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   output logic [W-1:0]          bus_rdata,
   input  logic [NBANK*W-1:0]    src_raw,
   output logic [NBANK-1:0]      irq_req,
   output logic [NBANK*IDX_W-1:0] irq_vec
);
   logic [BIDX_W-1:0] bidx;
   logic              hit;
   reg_sel_e          sel;
   logic [W-1:0]      st_q [NBANK];
   logic [W-1:0]      en_q [NBANK];
   logic [W-1:0]      mk_q [NBANK];
   logic [W-1:0]      rd_mux;

   initial begin
      if (NBANK < 1) $error("irq_bank_ctrl: need at least one bank");
   end

   irq_addr_dec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .bank_idx(bidx), .bank_hit(hit), .sel(sel));

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic sel_me;
      assign sel_me = hit && (bidx == BIDX_W'(g));
      irq_bank #(.W(W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .src(src_raw[g*W +: W]),
         .wr_stat(bus_wr && sel_me && sel == SEL_STATUS),
         .wr_en(bus_wr && sel_me && sel == SEL_ENABLE),
         .wdata(bus_wdata),
         .status(st_q[g]), .enable(en_q[g]), .masked(mk_q[g]),
         .req(irq_req[g]), .vec(irq_vec[g*IDX_W +: IDX_W]));
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (hit && bidx == BIDX_W'(b)) begin
            case (sel)
               SEL_STATUS: rd_mux = st_q[b];
               SEL_ENABLE: rd_mux = en_q[b];
               SEL_MASKED: rd_mux = mk_q[b];
               default:    rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rd_mux : '0;
   end

   // R10
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 5;

   logic         clk = 0;
   logic         rst_n = 0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic         bus_wr = 0, bus_rd = 0;
   logic [31:0]  bus_rdata;
   logic [159:0] src_raw = '0;
   logic [4:0]   irq_req;
   logic [24:0]  irq_vec;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_bank_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .src_raw(src_raw), .irq_req(irq_req),
      .irq_vec(irq_vec));

   // vector table: bank, source pattern, enable, expected req, vec (R8)
   typedef struct packed {
      logic [2:0]  bank;
      logic [31:0] src;
      logic [31:0] en;
      logic        req;
      logic [4:0]  vec;
   } vrow_t;
   localparam vrow_t TBL [6] = '{
      '{3'd0, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 5'd0},
      '{3'd1, 32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 5'd31},
      '{3'd2, 32'h0040_0100, 32'h0000_FFFF, 1'b1, 5'd8},
      '{3'd3, 32'h0F00_0000, 32'h00FF_FFFF, 1'b0, 5'd0},
      '{3'd4, 32'h0001_2000, 32'hFFFF_FFFF, 1'b1, 5'd16},
      '{3'd1, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 5'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); bus_addr = 12'(a); bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); bus_addr = 12'(a); bus_rd = 1;
      @(negedge clk); bus_rd = 0; d = bus_rdata;
   endtask

   task automatic pulse(input int b, input logic [31:0] p);
      @(negedge clk); src_raw[b*32 +: 32] = p;
      @(negedge clk); src_raw[b*32 +: 32] = '0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 50000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 req", 32'(irq_req), 0);
      chk("R1 rdata", bus_rdata, 0);
      rst_n = 1;
      rd(0, d);            chk("R1 status", d, 0);
      rd(8, d);            chk("R1 enable", d, 0);

      foreach (TBL[i]) begin
         automatic int b = TBL[i].bank;
         wr(b*'h28, 32'hFFFF_FFFF);
         wr(b*'h28 + 8, TBL[i].en);
         pulse(b, TBL[i].src);
         chk("R7 req", 32'(irq_req[b]), 32'(TBL[i].req));
         chk("R8 vec", 32'(irq_vec[b*5 +: 5]), 32'(TBL[i].vec));
         rd(b*'h28, d);    chk("R2 status", d, TBL[i].src);
         rd(b*'h28 + 'h10, d); chk("R6 masked", d, TBL[i].src & TBL[i].en);
      end

      // R3 partial clear on bank 2 (status 0x0040_0100)
      wr(2*'h28, 32'h0000_0100);
      rd(2*'h28, d); chk("R3 partial", d, 32'h0040_0000);
      wr(2*'h28, 32'hFFFF_FFFF);
      rd(2*'h28, d); chk("R3 all", d, 0);

      // R5 disable keeps status
      wr('h28 + 8, 32'h0);
      pulse(1, 32'h0000_0010);
      chk("R5 req low", 32'(irq_req[1]), 0);
      rd('h28, d); chk("R5 status kept", d, 32'h0000_0010);
      wr('h28 + 8, 32'h0000_0010);
      chk("R7 req after enable", 32'(irq_req[1]), 1);

      // R4 collision: source high while clearing
      @(negedge clk);
      src_raw[32 +: 32] = 32'h0000_0010;
      bus_addr = 12'h28; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1;
      @(negedge clk); bus_wr = 0; src_raw = '0;
      rd('h28, d); chk("R4 kept", d, 32'h0000_0010);

      // R6 write to masked ignored
      wr('h28 + 'h10, 32'h0);
      rd('h28 + 'h10, d); chk("R6 write ignored", d, 32'h0000_0010);

      // R9 reserved offsets and out of range
      wr(4*'h28 + 'h18, 32'hFFFF_FFFF);
      wr(4*'h28 + 'h20, 32'hFFFF_FFFF);
      rd(4*'h28 + 'h18, d); chk("R9 rsvd18", d, 0);
      rd(4*'h28 + 'h20, d); chk("R9 rsvd20", d, 0);
      rd(4*'h28 + 8, d);    chk("R9 enable untouched", d, 32'hFFFF_FFFF);
      rd(4*'h28, d);        chk("R9 status untouched", d, 32'h0001_2000);
      rd('h200, d);         chk("R9 out of range", d, 0);

      // R10 no strobe gives zero read data
      @(negedge clk); bus_addr = 12'h28;
      @(negedge clk); chk("R10 idle rdata", bus_rdata, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule